// File: doc/BRIEF.md
# AAL5 Transmit Segmentation State Engine

This block holds the transmit state of one channel while a host packet is cut into fixed 48-byte cells. The packet can sit in one buffer or in several, and each buffer may start at any byte address. A descriptor loader hands the engine one buffer at a time through a valid/ready port. The first buffer of a packet also brings the header word, the AAL-type bit and the packet cell count.

A data mover moves payload into the cell buffer. It reports each move with a byte-count strobe and keeps each move within the bytes left in the buffer and the room left in the current cell. For each move the engine advances its buffer pointer and adds to its two length counters, which count upward from negative values toward zero. It closes a cell when the cell reaches 48 bytes, or when the final buffer of the packet runs dry. When it closes a cell it presents the 32-bit cell header, and the last cell of a packet takes its own PTI and CLP bits. A cell that has not been filled continues into the next buffer of the same packet.

Top module: `aal5_tx_seg_engine`

## Requirements
- R1: After reset `load_ready` is 1. `busy`, `start_flag`, `cell_valid`, `aal_err` and `len_mismatch` are 0, and `cell_room` is 48.
- R2: `load_ready` is 1 only when no buffer is in progress and no error is held. An accepted load makes `busy` 1 and loads `cur_ptr` from `load_ptr`. Each transfer of N bytes then adds N to `cur_ptr`.
- R3: `load_buf_len` is the negative byte count of the buffer, and `buf_left` shows its positive value. Each transfer adds its byte count to the counter. When the counter reaches zero the buffer is finished, so `busy` falls and `load_ready` rises in the same cycle that the transfer is registered.
- R4: A cell holds 48 bytes, and `cell_room` shows the bytes still free in it. `cell_valid` is a one-cycle pulse in the cycle after the transfer that fills the cell. A partly filled cell keeps its fill across buffers and continues from the next buffer.
- R5: Each closed cell adds one to the packet counter, which is loaded from the negative count in `load_pkt_len`. The cell closed when the buffer flagged end-of-chain (`load_eoc`=1) runs dry is the last cell, with `cell_last`=1, even if it is only partly filled.
- R6: If the packet counter is not zero after the last cell, `len_mismatch` is set. It stays set until the next start-of-chain load.
- R7: The header word is taken only from a load with `load_soc`=1. It is held for every cell of that packet, and loads with `load_soc`=0 do not change it.
- R8: For a cell that is not the last, `cell_hdr` is {4'h0, hdr[27:0]}. The top nibble (GFC) is zero, VPI is in bits 27–20, VCI in bits 19–4, PTI in bits 3–1 and CLP in bit 0.
- R9: For the last cell, `cell_hdr` is {4'h0, hdr[27:4], hdr[31:29], hdr[28]}. Header bits 31–29 replace the PTI, and bit 28 replaces the CLP.
- R10: `start_flag` rises on a load with `load_soc`=1 and falls when that first buffer runs dry.
- R11: A load with `load_soc`=0 whose `load_aal` differs from the bit latched at the start of the packet sets `aal_err`. The buffer is not started, and `load_ready` stays 0 until reset. `load_aal`=0 denotes AAL5.
- R12: A transfer strobe while `busy` is 0 has no effect. `cur_ptr`, `cell_room` and `cell_valid` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_valid | input | 1 | Descriptor offered |
| load_ready | output | 1 | Engine accepts a descriptor |
| load_soc | input | 1 | First buffer of a packet |
| load_eoc | input | 1 | Final buffer of a packet |
| load_aal | input | 1 | AAL-type bit, 0 for AAL5 |
| load_pkt_len | input | 11 | Negative cell count of the packet |
| load_buf_len | input | 16 | Negative byte count of the buffer |
| load_ptr | input | 32 | Start byte address of the buffer |
| load_hdr | input | 32 | Header word of the packet |
| xfer_valid | input | 1 | Payload transfer strobe |
| xfer_bytes | input | 6 | Bytes moved in this transfer |
| busy | output | 1 | A buffer is in progress |
| start_flag | output | 1 | First buffer of the packet still in progress |
| cur_ptr | output | 32 | Current byte address in the buffer |
| buf_left | output | 16 | Bytes left in the buffer |
| cell_room | output | 6 | Bytes still free in the current cell |
| cell_valid | output | 1 | One-cycle pulse when a cell closes |
| cell_last | output | 1 | The closed cell ends the packet |
| cell_hdr | output | 32 | Header of the closed cell |
| aal_err | output | 1 | AAL-type mismatch, channel stopped |
| len_mismatch | output | 1 | Packet count did not reach zero |

## Verification
Some properties are checked by assertions on every cycle:
- the pointer steps by each transfer's byte count;
- the cell fill stays below 48, and every transfer fits both the cell and the buffer;
- the header word holds between start-of-chain loads;
- the GFC nibble is always zero;
- the error stays set and blocks loads;
- a last cell always leaves the engine idle.

Other behaviours can only be shown by the bench's directed scenarios, because they depend on exact stimulus and values:
- where cells close, and the exact header bits of last and non-last cells;
- a cell filled across two buffers;
- the length-mismatch flag;
- when the start flag clears;
- a refused load after an AAL-type mismatch.

// File: rtl/aal5_tx_seg_engine.sv
module aal5_tx_seg_engine #(
  parameter int CELL_BYTES = 48,
  parameter int PKT_W      = 11,
  parameter int BUF_W      = 16,
  parameter int ADDR_W     = 32,
  parameter int CW         = $clog2(CELL_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic              load_soc,
  input  logic              load_eoc,
  input  logic              load_aal,
  input  logic [PKT_W-1:0]  load_pkt_len,
  input  logic [BUF_W-1:0]  load_buf_len,
  input  logic [ADDR_W-1:0] load_ptr,
  input  logic [31:0]       load_hdr,
  input  logic              xfer_valid,
  input  logic [CW-1:0]     xfer_bytes,
  output logic              busy,
  output logic              start_flag,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [BUF_W-1:0]  buf_left,
  output logic [CW-1:0]     cell_room,
  output logic              cell_valid,
  output logic              cell_last,
  output logic [31:0]       cell_hdr,
  output logic              aal_err,
  output logic              len_mismatch
);

  logic              active, soc_q, eoc_q, aal_q, err_q, mism_q;
  logic [PKT_W-1:0]  pkt_cnt;
  logic [BUF_W-1:0]  buf_cnt;
  logic [ADDR_W-1:0] ptr;
  logic [31:0]       hdr;
  logic [CW-1:0]     fill;

  assign load_ready = !active && !err_q;

  wire              take     = load_valid && load_ready;
  wire              aal_bad  = take && !load_soc && (load_aal != aal_q);
  wire              step     = active && xfer_valid;
  wire [BUF_W-1:0]  buf_nxt  = buf_cnt + BUF_W'(xfer_bytes);
  wire [CW-1:0]     fill_nxt = fill + xfer_bytes;
  wire              buf_end  = step && (buf_nxt == '0);
  wire              last_end = buf_end && eoc_q;
  wire              close    = step && ((fill_nxt == CW'(CELL_BYTES)) || last_end);
  wire [PKT_W-1:0]  pkt_nxt  = pkt_cnt + 1'b1;
  wire [31:0]       hdr_mid  = {4'h0, hdr[27:0]};
  wire [31:0]       hdr_end  = {4'h0, hdr[27:4], hdr[31:29], hdr[28]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active     <= 1'b0;
      soc_q      <= 1'b0;
      eoc_q      <= 1'b0;
      aal_q      <= 1'b0;
      err_q      <= 1'b0;
      mism_q     <= 1'b0;
      pkt_cnt    <= '0;
      buf_cnt    <= '0;
      ptr        <= '0;
      hdr        <= '0;
      fill       <= '0;
      cell_valid <= 1'b0;
      cell_last  <= 1'b0;
      cell_hdr   <= '0;
    end else begin
      cell_valid <= close;
      if (close) begin
        cell_last <= last_end;
        cell_hdr  <= last_end ? hdr_end : hdr_mid;
      end
      if (take) begin
        if (aal_bad) begin
          err_q <= 1'b1;
        end else begin
          active  <= 1'b1;
          ptr     <= load_ptr;
          buf_cnt <= load_buf_len;
          eoc_q   <= load_eoc;
          soc_q   <= load_soc;
          if (load_soc) begin
            hdr     <= load_hdr;
            pkt_cnt <= load_pkt_len;
            aal_q   <= load_aal;
            mism_q  <= 1'b0;
            fill    <= '0;
          end
        end
      end
      if (step) begin
        ptr     <= ptr + ADDR_W'(xfer_bytes);
        buf_cnt <= buf_nxt;
        fill    <= close ? '0 : fill_nxt;
        if (close) pkt_cnt <= pkt_nxt;
        if (buf_end) begin
          active <= 1'b0;
          soc_q  <= 1'b0;
        end
        if (last_end && (pkt_nxt != '0)) mism_q <= 1'b1;
      end
    end
  end

  assign busy         = active;
  assign start_flag   = soc_q;
  assign cur_ptr      = ptr;
  assign buf_left     = '0 - buf_cnt;
  assign cell_room    = CW'(CELL_BYTES) - fill;
  assign aal_err      = err_q;
  assign len_mismatch = mism_q;

  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cur_ptr == $past(ptr + ADDR_W'(xfer_bytes)));

  a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) < CELL_BYTES);

  a_r4_xfer_fits: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (xfer_bytes <= cell_room) && (BUF_W'(xfer_bytes) <= buf_left));

  a_r5_last_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_valid && cell_last) |-> !busy);

  a_r7_hdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && load_soc && !aal_bad) |=> $stable(hdr));

  a_r8_gfc_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cell_valid |-> cell_hdr[31:28] == 4'h0);

  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    aal_err |=> aal_err && !load_ready);

  a_r12_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> $stable(cur_ptr));

endmodule

// File: tb/test_aal5_tx_seg_engine.sv
`timescale 1ns/1ps
module test_aal5_tx_seg_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_valid = 1'b0, load_soc = 1'b0, load_eoc = 1'b0, load_aal = 1'b0;
  logic [10:0] load_pkt_len = '0;
  logic [15:0] load_buf_len = '0;
  logic [31:0] load_ptr = '0, load_hdr = '0;
  logic        xfer_valid = 1'b0;
  logic [5:0]  xfer_bytes = '0;
  logic        load_ready, busy, start_flag, cell_valid, cell_last, aal_err, len_mismatch;
  logic [31:0] cur_ptr, cell_hdr;
  logic [15:0] buf_left;
  logic [5:0]  cell_room;
  int n_cmp = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  aal5_tx_seg_engine i_aal5_tx_seg_engine (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_ready(load_ready),
    .load_soc(load_soc), .load_eoc(load_eoc), .load_aal(load_aal),
    .load_pkt_len(load_pkt_len), .load_buf_len(load_buf_len), .load_ptr(load_ptr),
    .load_hdr(load_hdr), .xfer_valid(xfer_valid), .xfer_bytes(xfer_bytes),
    .busy(busy), .start_flag(start_flag), .cur_ptr(cur_ptr), .buf_left(buf_left),
    .cell_room(cell_room), .cell_valid(cell_valid), .cell_last(cell_last),
    .cell_hdr(cell_hdr), .aal_err(aal_err), .len_mismatch(len_mismatch));

  function automatic logic [31:0] fmt(input logic [31:0] h, input logic last);
    return last ? {4'h0, h[27:4], h[31:29], h[28]} : {4'h0, h[27:0]};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic load(input logic soc, input logic eoc, input logic aal, input int pkt_cells,
                      input int bytes, input logic [31:0] p, input logic [31:0] h);
    load_valid = 1'b1; load_soc = soc; load_eoc = eoc; load_aal = aal;
    load_pkt_len = 11'(-pkt_cells); load_buf_len = 16'(-bytes); load_ptr = p; load_hdr = h;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic xfer(input int n);
    xfer_valid = 1'b1; xfer_bytes = 6'(n);
    @(negedge clk);
    xfer_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(load_ready, 1, "R1 load_ready");
    chk(busy, 0, "R1 busy");
    chk(start_flag, 0, "R1 start_flag");
    chk(cell_valid, 0, "R1 cell_valid");
    chk(aal_err, 0, "R1 aal_err");
    chk(len_mismatch, 0, "R1 len_mismatch");
    chk(cell_room, 48, "R1 cell_room");
  endtask

  task automatic t_single();
    load(1, 1, 0, 2, 96, 32'h1000, 32'hA1234567);
    chk(busy, 1, "R2 busy after load");
    chk(load_ready, 0, "R2 ready low");
    chk(cur_ptr, 32'h1000, "R2 ptr load");
    chk(buf_left, 96, "R3 buf_left");
    chk(start_flag, 1, "R10 start_flag set");
    xfer(48);
    chk(cell_valid, 1, "R4 full cell closes");
    chk(cell_last, 0, "R5 not last");
    chk(cell_hdr, fmt(32'hA1234567, 0), "R8 mid header");
    chk(cur_ptr, 32'h1030, "R2 ptr advance");
    chk(buf_left, 48, "R3 buf_left after 48");
    xfer(20);
    chk(cell_valid, 0, "R4 partial no close");
    chk(cell_room, 28, "R4 cell_room");
    xfer(28);
    chk(cell_valid, 1, "R5 last close");
    chk(cell_last, 1, "R5 last flag");
    chk(cell_hdr, 32'h0123456A, "R9 last header");
    chk(len_mismatch, 0, "R6 no mismatch");
    chk(busy, 0, "R3 buffer done");
    chk(load_ready, 1, "R3 ready again");
    @(negedge clk);
    chk(cell_valid, 0, "R4 one-cycle pulse");
  endtask

  task automatic t_span();
    load(1, 0, 0, 1, 30, 32'h2000, 32'h5ABCDEF1);
    xfer(30);
    chk(cell_valid, 0, "R4 no close at buffer end");
    chk(busy, 0, "R3 first buffer done");
    chk(start_flag, 0, "R10 start_flag cleared");
    chk(cell_room, 18, "R4 fill kept");
    chk(cur_ptr, 32'h201E, "R2 ptr span");
    load(0, 1, 0, 7, 18, 32'h3000, 32'hFFFFFFFF);
    chk(start_flag, 0, "R10 no start on second buffer");
    chk(cell_room, 18, "R4 fill across buffers");
    xfer(10);
    xfer(8);
    chk(cell_valid, 1, "R4 spanned cell closes");
    chk(cell_last, 1, "R5 spanned last");
    chk(cell_hdr, 32'h0ABCDEF5, "R7 header held from first buffer");
    chk(cur_ptr, 32'h3012, "R2 ptr second buffer");
    chk(len_mismatch, 0, "R6 count matched");
  endtask

  task automatic t_mismatch();
    load(1, 1, 0, 3, 48, 32'h4000, 32'h00000010);
    xfer(48);
    chk(cell_last, 1, "R5 eoc drain is last");
    chk(len_mismatch, 1, "R6 mismatch set");
    load(1, 1, 0, 1, 4, 32'h5000, 32'h0);
    chk(len_mismatch, 0, "R6 cleared on new packet");
    xfer(4);
    chk(cell_valid, 1, "R5 short last cell");
  endtask

  task automatic t_idle_xfer();
    xfer(12);
    chk(cell_valid, 0, "R12 no cell");
    chk(cell_room, 48, "R12 room unchanged");
    chk(cur_ptr, 32'h5004, "R12 ptr unchanged");
  endtask

  task automatic t_aal_err();
    load(1, 0, 0, 1, 10, 32'h6000, 32'h0);
    xfer(10);
    load(0, 1, 1, 1, 38, 32'h7000, 32'h0);
    chk(aal_err, 1, "R11 error set");
    chk(load_ready, 0, "R11 channel stopped");
    chk(busy, 0, "R11 buffer not started");
    load(0, 1, 0, 1, 38, 32'h7000, 32'h0);
    chk(busy, 0, "R11 load refused");
    do_reset();
    chk(aal_err, 0, "R11 cleared by reset");
    chk(load_ready, 1, "R11 ready after reset");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    t_reset();
    t_single();
    t_span();
    t_mismatch();
    t_idle_xfer();
    t_aal_err();
    finish_run();
  end
endmodule